// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two small square matrices of signed integers, C = A·B, on an N×N grid of multiply-accumulate cells. One operand streams in along the left edge and travels rightward cell by cell. The other streams in along the top edge and travels downward. Each cell keeps its own running sum and never moves it during the multiply phase. The block staggers both operand streams internally, so the caller presents one column of A and one row of B per cycle with no alignment of its own. Once the last operand pair has met, the finished sums shift down through the grid and leave the bottom edge one row per cycle.

A job starts with a single-cycle start pulse. That same cycle carries the first operand beat. The remaining N−1 beats follow on consecutive cycles. After the real beats the cells are fed zeros, so the extra cycles leave the sums unchanged. A new job may start in the cycle right after the last result row.

Top module: `sysmm_top`

## Requirements
- R1: After reset, res_valid and res_last are low and res_row is zero. They stay that way until a job has run.
- R2: Each result element C[r][c] equals the sum over k of A[r][k]·B[k][c]. The operands are DW-bit two's complement values. The sum is formed in AW-bit two's complement.
- R3: Beat k (k = 0..N−1) is taken on the k-th cycle counting from the start cycle as 0. On a_col, bits [i*DW +: DW] carry A[i][k]. On b_row, bits [j*DW +: DW] carry B[k][j]. If op_valid is low in one of these cycles, that beat counts as all zeros.
- R4: Operand data presented after beat N−1 does not change any result, whatever the value of op_valid.
- R5: The first result row appears exactly 3N−2 cycles after the start cycle. All N rows appear on consecutive cycles with res_valid high, and res_valid is low at every other time.
- R6: Rows leave in the order row N−1 first and row 0 last. On res_row, bits [c*AW +: AW] carry C[r][c].
- R7: res_last is high only with the final row (row 0) and never without res_valid.
- R8: A start pulse is ignored while a job is in its multiply or drain phase. A start in the cycle after the last row begins a new job, and that job's results do not depend on any earlier job.
- R9: Reset during a job abandons it, and no result row is emitted for the abandoned job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a job when the block is idle; carries beat 0 |
| op_valid | input | 1 | The current operand beat is real data |
| a_col | input | N*DW | One column of A, lane i = row i |
| b_row | input | N*DW | One row of B, lane j = column j |
| res_valid | output | 1 | A result row is present |
| res_last | output | 1 | The present row is the final one |
| res_row | output | N*AW | One row of C, lane c = column c |

## Verification
Two functions can fall in the same cycle: the final drained row (with res_last) and a start pulse for the next job. The bench drives a start pulse in the last-row cycle and another in the middle of the multiply phase. It then checks that the results and the row timing of that job are unchanged. A start in the very next cycle runs a fresh job back to back, with its row timing measured from that later pulse.

// File: rtl/sysmm_pkg.sv
`timescale 1ns/1ps
package sysmm_pkg;

    // Job phase of the controller.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MUL   = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    // Per-cycle command broadcast to every cell.
    typedef struct packed {
        logic clr;    // restart the sum with this cycle's product
        logic mac;    // add this cycle's product
        logic shift;  // take the sum of the cell above
    } cell_ctl_t;

    // Cycles from the start cycle until the last operand pair meets.
    function automatic int mul_cycles(input int n);
        return 3 * n - 2;
    endfunction

endpackage

// File: rtl/sysmm_ctrl.sv
`timescale 1ns/1ps
module sysmm_ctrl
    import sysmm_pkg::*;
#(
    parameter int N = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      op_valid,
    output logic      accept,
    output cell_ctl_t ctl,
    output phase_e    phase,
    output logic      res_valid,
    output logic      res_last
);
    localparam int LAST_STEP = mul_cycles(N) - 1;
    localparam int CW        = $clog2(3 * N) + 1;

    logic [CW-1:0] cnt;
    logic          start_ok;

    assign start_ok = start && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (LAST_STEP == 0) begin
                            phase <= PH_DRAIN;
                            cnt   <= '0;
                        end else begin
                            phase <= PH_MUL;
                            cnt   <= CW'(1);
                        end
                    end
                end
                PH_MUL: begin
                    if (cnt == CW'(LAST_STEP)) begin
                        phase <= PH_DRAIN;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_DRAIN: begin
                    if (cnt == CW'(N - 1)) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Beats are taken only in steps 0..N-1 of the multiply phase.
    assign accept    = op_valid && (start_ok || ((phase == PH_MUL) && (cnt < CW'(N))));
    assign ctl.clr   = start_ok;
    assign ctl.mac   = (phase == PH_MUL);
    assign ctl.shift = (phase == PH_DRAIN);
    assign res_valid = (phase == PH_DRAIN);
    assign res_last  = (phase == PH_DRAIN) && (cnt == CW'(N - 1));

endmodule

// File: rtl/sysmm_skew.sv
`timescale 1ns/1ps
module sysmm_skew #(
    parameter int DW    = 8,
    parameter int DELAY = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    generate
        if (DELAY == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            logic [DW-1:0] line [DELAY];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < DELAY; k++) line[k] <= '0;
                end else begin
                    line[0] <= din;
                    for (int k = 1; k < DELAY; k++) line[k] <= line[k-1];
                end
            end
            assign dout = line[DELAY-1];
        end
    endgenerate
endmodule

// File: rtl/sysmm_pe.sv
`timescale 1ns/1ps
module sysmm_pe
    import sysmm_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  cell_ctl_t     ctl,
    input  logic [DW-1:0] west,
    input  logic [DW-1:0] north,
    input  logic [AW-1:0] acc_in,
    output logic [DW-1:0] east,
    output logic [DW-1:0] south,
    output logic [AW-1:0] acc_q
);
    logic signed [2*DW-1:0] prod;
    logic        [AW-1:0]   prod_x;

    assign prod   = $signed(west) * $signed(north);
    assign prod_x = AW'(prod);

    always_ff @(posedge clk) begin
        if (rst) begin
            east  <= '0;
            south <= '0;
            acc_q <= '0;
        end else begin
            east  <= west;
            south <= north;
            if (ctl.clr)        acc_q <= prod_x;
            else if (ctl.mac)   acc_q <= acc_q + prod_x;
            else if (ctl.shift) acc_q <= acc_in;
        end
    end
endmodule

// File: rtl/sysmm_top.sv
`timescale 1ns/1ps
module sysmm_top
    import sysmm_pkg::*;
#(
    parameter int N  = 3,
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_valid,
    input  logic [N*DW-1:0] a_col,
    input  logic [N*DW-1:0] b_row,
    output logic          res_valid,
    output logic          res_last,
    output logic [N*AW-1:0] res_row
);
    logic      accept_w;
    cell_ctl_t ctl_w;
    phase_e    phase_w;

    logic [DW-1:0] a_sk [N];
    logic [DW-1:0] b_sk [N];
    logic [DW-1:0] east_w  [N][N];
    logic [DW-1:0] south_w [N][N];
    logic [AW-1:0] acc_w   [N][N];

    sysmm_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_valid  (op_valid),
        .accept    (accept_w),
        .ctl       (ctl_w),
        .phase     (phase_w),
        .res_valid (res_valid),
        .res_last  (res_last)
    );

    // Edge lanes: zero filler unless a beat is accepted, lane i delayed i cycles.
    for (genvar i = 0; i < N; i++) begin : g_edge
        logic [DW-1:0] a_in, b_in;
        assign a_in = accept_w ? a_col[i*DW +: DW] : '0;
        assign b_in = accept_w ? b_row[i*DW +: DW] : '0;

        sysmm_skew #(.DW(DW), .DELAY(i)) u_skew_a (
            .clk(clk), .rst(rst), .din(a_in), .dout(a_sk[i])
        );
        sysmm_skew #(.DW(DW), .DELAY(i)) u_skew_b (
            .clk(clk), .rst(rst), .din(b_in), .dout(b_sk[i])
        );
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            logic [DW-1:0] w_in, n_in;
            logic [AW-1:0] up_acc;

            if (c == 0) begin : g_wl
                assign w_in = a_sk[r];
            end else begin : g_wi
                assign w_in = east_w[r][c-1];
            end

            if (r == 0) begin : g_nt
                assign n_in   = b_sk[c];
                assign up_acc = '0;
            end else begin : g_ni
                assign n_in   = south_w[r-1][c];
                assign up_acc = acc_w[r-1][c];
            end

            sysmm_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk    (clk),
                .rst    (rst),
                .ctl    (ctl_w),
                .west   (w_in),
                .north  (n_in),
                .acc_in (up_acc),
                .east   (east_w[r][c]),
                .south  (south_w[r][c]),
                .acc_q  (acc_w[r][c])
            );
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_out
        assign res_row[c*AW +: AW] = acc_w[N-1][c];
    end

endmodule

// File: rtl/sysmm_chk.sv
`timescale 1ns/1ps
module sysmm_chk
    import sysmm_pkg::*;
#(
    parameter int N = 3
) (
    input logic   clk,
    input logic   rst,
    input logic   start,
    input logic   accept,
    input phase_e phase,
    input logic   res_valid,
    input logic   res_last
);
    localparam int CW = $clog2(4 * N) + 2;

    logic [CW-1:0] since;
    logic          running;
    logic [CW-1:0] rows;

    always_ff @(posedge clk) begin
        if (rst) begin
            since   <= '0;
            running <= 1'b0;
            rows    <= '0;
        end else begin
            if (start && phase == PH_IDLE) begin
                since   <= CW'(1);
                running <= 1'b1;
            end else if (running) begin
                since <= since + CW'(1);
                if (res_last) running <= 1'b0;
            end
            rows <= (res_valid && !res_last) ? rows + CW'(1) : '0;
        end
    end

    // R5: first row exactly 3N-2 cycles after the accepted start
    a_r5_first_row_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> (running && since == CW'(mul_cycles(N))));

    // R5: rows come on consecutive cycles
    a_r5_rows_contiguous: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_last) |=> res_valid);

    // R7: last marks the N-th row and ends the burst
    a_r7_last_is_nth_row: assert property (@(posedge clk) disable iff (rst)
        res_last |-> (res_valid && rows == CW'(N - 1)));

    a_r7_burst_ends: assert property (@(posedge clk) disable iff (rst)
        res_last |=> !res_valid);

    // R4: no operand is taken while results drain
    a_r4_no_accept_in_drain: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !accept);

endmodule

bind sysmm_top sysmm_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .accept    (accept_w),
    .phase     (phase_w),
    .res_valid (res_valid),
    .res_last  (res_last)
);

// File: tb/tb_sysmm_top.sv
`timescale 1ns/1ps
module tb_sysmm_top;
    localparam int N  = 3;
    localparam int DW = 8;
    localparam int AW = 20;
    localparam int NJ = 4;

    // Operand table, row-major: entry [r*N+k].
    localparam int TA [NJ][N*N] = '{
        '{1, 0, 0, 0, 1, 0, 0, 0, 1},
        '{1, 2, 3, 4, 5, 6, 7, 8, 9},
        '{-128, -128, -128, -128, -128, -128, -128, -128, -128},
        '{-1, 2, -3, 4, -5, 6, -7, 8, -9}
    };
    localparam int TB [NJ][N*N] = '{
        '{1, 2, 3, 4, 5, 6, 7, 8, 9},
        '{9, -8, 7, 6, -5, 4, 3, 2, -1},
        '{-128, -128, -128, -128, -128, -128, -128, -128, -128},
        '{127, -128, 0, 5, -6, 7, -8, 9, 10}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic op_valid = 1'b0;
    logic [N*DW-1:0] a_col = '0;
    logic [N*DW-1:0] b_row = '0;
    logic res_valid, res_last;
    logic [N*AW-1:0] res_row;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sysmm_top #(.N(N), .DW(DW), .AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .op_valid(op_valid),
        .a_col(a_col), .b_row(b_row),
        .res_valid(res_valid), .res_last(res_last), .res_row(res_row)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One job: bubble = beat index driven with op_valid low (-1 none),
    // noisy = extra start pulses and garbage beats after beat N-1.
    task automatic run_job(input int j, input int bubble, input bit noisy, input string tag);
        int expc [N][N];
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                expc[r][c] = 0;
                for (int k = 0; k < N; k++)
                    if (k != bubble) expc[r][c] += TA[j][r*N+k] * TB[j][k*N+c];
            end
        for (int s = 0; s < 4*N-2; s++) begin
            bit want_v;
            want_v = (s >= 3*N-2) && (s <= 4*N-3);
            check(res_valid == want_v, "R5", {tag, " res_valid timing"}, res_valid, want_v);
            check(res_last == (s == 4*N-3), "R7", {tag, " res_last"}, res_last, (s == 4*N-3));
            if (want_v) begin
                int r;
                r = N-1-(s-(3*N-2));
                for (int c = 0; c < N; c++) begin
                    logic [AW-1:0] e;
                    e = expc[r][c][AW-1:0];
                    check(res_row[c*AW +: AW] == e, "R2 R6", {tag, " result element"},
                          res_row[c*AW +: AW], e);
                end
            end
            // R8: extra start pulses mid-multiply and with the last row
            start = (s == 0) || (noisy && (s == N+1 || s == 4*N-3));
            if (s < N) begin
                op_valid = (s != bubble);
                for (int i = 0; i < N; i++) begin
                    a_col[i*DW +: DW] = DW'(TA[j][i*N+s]);
                    b_row[i*DW +: DW] = DW'(TB[j][s*N+i]);
                end
            end else begin
                // R4: late data must not reach any sum
                op_valid = noisy;
                a_col = noisy ? '1 : '0;
                b_row = noisy ? {N{8'h5a}} : '0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        op_valid = 1'b0;
        a_col = '0;
        b_row = '0;
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(res_last == 1'b0, "R1", "res_last after reset", res_last, 0);
        check(res_row == '0, "R1", "res_row after reset", res_row, 0);

        // R2 R3 R5 R6 R7: plain jobs from the table
        for (int j = 0; j < NJ; j++) run_job(j, -1, 1'b0, "plain");
        // R3: bubble beat counts as zero
        run_job(1, 1, 1'b0, "R3 bubble");
        // R4 R8: garbage beats and ignored starts, then back-to-back job
        run_job(3, -1, 1'b1, "R4 R8 noisy");
        run_job(2, -1, 1'b1, "R8 back-to-back");
        run_job(0, 0, 1'b0, "R3 first beat bubble");

        // R9: reset in the middle of a job
        start = 1'b1; op_valid = 1'b1; a_col = '1; b_row = '1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; op_valid = 1'b0; a_col = '0; b_row = '0;
        for (int s = 0; s < 4*N; s++) begin
            check(res_valid == 1'b0, "R9", "no row after reset mid-job", res_valid, 0);
            @(negedge clk);
        end
        // R9: a fresh job after the abandoned one is correct
        run_job(1, -1, 1'b0, "R9 recovery");
        check(res_valid == 1'b0, "R5", "idle after final job", res_valid, 0);

        finish_run();
    end
endmodule